// File: doc/BRIEF.md
# Bridging Fault Emulation Wrapper

This block sits between a bank of signal pairs and the logic that consumes them, so that a short between two neighbouring wires can be emulated in hardware. Each pair has an "A" source and a "B" source on the way in, and an "A" and a "B" destination on the way out. While emulation is off, every destination follows its own source. While it is on, one chosen pair is replaced by one of eight bridge behaviours: wired-AND, wired-OR, full dominance by either wire, or dominant-AND and dominant-OR in either direction.

A small configuration register holds the enable bit, a 4-bit bridge code and the index of the targeted pair. It is loaded in one clock cycle through a write strobe. The data path itself is purely combinational, so a bridge takes effect on the destinations within the same cycle as the source values.

Each pair also drives a flag that models detection by quiescent supply current. The flag is high when the bridge is active on that pair and its two sources fight, meaning they drive opposite levels.

Top module: `bridge_fault_inj`

## Requirements
- R1: After reset, the configuration holds enable=0, code=0 and target=0, and every destination equals its source.
- R2: When `cfg_wr` is high at a rising clock edge, enable, code and target are loaded from `cfg_en`, `cfg_code` and `cfg_target`, and they affect the outputs from the next cycle. When `cfg_wr` is low, the configuration inputs have no effect on the outputs.
- R3: With the enable bit clear, `dst_a[i]==src_a[i]` and `dst_b[i]==src_b[i]` for every pair, whatever the code and target are.
- R4: Code 1 (wired-AND) drives both destinations of the targeted pair to A&B. Code 2 (wired-OR) drives both to A|B.
- R5: Code 3 (A dominates) drives both destinations to A. Code 4 (B dominates) drives both to B.
- R6: Code 5 gives dst_a=A and dst_b=A&B. Code 6 gives dst_b=B and dst_a=A&B.
- R7: Code 7 gives dst_a=A and dst_b=A|B. Code 8 gives dst_b=B and dst_a=A|B.
- R8: Code 0 and codes 9 to 15 pass the targeted pair through unchanged.
- R9: Only the pair whose index equals the target is altered. A target of `NUM_PAIRS` or above alters no pair.
- R10: `short_flag[i]` is high, in the same cycle, exactly when the enable bit is set, pair i is the target, the code is 1 to 8 and `src_a[i]!=src_b[i]`. It is zero for every other pair, so at most one flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration load strobe |
| cfg_en | input | 1 | Bridge enable value to load |
| cfg_code | input | 4 | Bridge code value to load |
| cfg_target | input | TGT_W | Pair index value to load |
| src_a | input | NUM_PAIRS | A-side source of each pair |
| src_b | input | NUM_PAIRS | B-side source of each pair |
| dst_a | output | NUM_PAIRS | A-side destination of each pair |
| dst_b | output | NUM_PAIRS | B-side destination of each pair |
| short_flag | output | NUM_PAIRS | Per-pair supply-current detection flag |

## Verification
On every cycle, the assertions check the following:
- every pair passes through while the enable bit is clear;
- non-target pairs are untouched;
- an invalid code leaves the target untouched;
- at most one detection flag is high, and only on a pair whose sources differ;
- the configuration holds without a write strobe.

The exact truth table of each of the eight bridge codes, the one-cycle delay before a new configuration takes effect, and out-of-range targets are shown only by the bench's scenarios. The bench sweeps every code against every target, including indices beyond the last pair, with random source patterns, and compares each cycle against its behavioural model.

// File: rtl/bridge_fault_inj.sv
module bridge_fault_inj #(
  parameter int NUM_PAIRS = 6,
  parameter int TGT_W     = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic                 cfg_en,
  input  logic [3:0]           cfg_code,
  input  logic [TGT_W-1:0]     cfg_target,
  input  logic [NUM_PAIRS-1:0] src_a,
  input  logic [NUM_PAIRS-1:0] src_b,
  output logic [NUM_PAIRS-1:0] dst_a,
  output logic [NUM_PAIRS-1:0] dst_b,
  output logic [NUM_PAIRS-1:0] short_flag
);

  localparam logic [3:0] C_WAND  = 4'd1;
  localparam logic [3:0] C_WOR   = 4'd2;
  localparam logic [3:0] C_ADOM  = 4'd3;
  localparam logic [3:0] C_BDOM  = 4'd4;
  localparam logic [3:0] C_ADAND = 4'd5;
  localparam logic [3:0] C_BDAND = 4'd6;
  localparam logic [3:0] C_ADOR  = 4'd7;
  localparam logic [3:0] C_BDOR  = 4'd8;

  logic             en_q;
  logic [3:0]       code_q;
  logic [TGT_W-1:0] tgt_q;
  logic             code_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      code_q <= '0;
      tgt_q  <= '0;
    end else if (cfg_wr) begin
      en_q   <= cfg_en;
      code_q <= cfg_code;
      tgt_q  <= cfg_target;
    end
  end

  assign code_ok = (code_q >= C_WAND) && (code_q <= C_BDOR);

  function automatic logic [1:0] bridge_f(input logic [3:0] k, input logic a, input logic b);
    case (k)
      C_WAND:  return {a & b, a & b};
      C_WOR:   return {a | b, a | b};
      C_ADOM:  return {a, a};
      C_BDOM:  return {b, b};
      C_ADAND: return {a, a & b};
      C_BDAND: return {a & b, b};
      C_ADOR:  return {a, a | b};
      C_BDOR:  return {a | b, b};
      default: return {a, b};
    endcase
  endfunction

  for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
    logic       hit;
    logic [1:0] res;

    assign hit           = en_q && (tgt_q == TGT_W'(i));
    assign res           = hit ? bridge_f(code_q, src_a[i], src_b[i]) : {src_a[i], src_b[i]};
    assign dst_a[i]      = res[1];
    assign dst_b[i]      = res[0];
    assign short_flag[i] = hit && code_ok && (src_a[i] ^ src_b[i]);

    p_off_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> (dst_a[i] == src_a[i]) && (dst_b[i] == src_b[i]));

    p_other_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_q != TGT_W'(i)) |-> (dst_a[i] == src_a[i]) && (dst_b[i] == src_b[i]) && !short_flag[i]);

    p_bad_code_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !code_ok |-> (dst_a[i] == src_a[i]) && (dst_b[i] == src_b[i]));

    p_flag_fight_r10: assert property (@(posedge clk) disable iff (!rst_n)
      short_flag[i] |-> (src_a[i] != src_b[i]) && en_q);
  end

  p_flag_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(short_flag));

  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(en_q) && $stable(code_q) && $stable(tgt_q));

endmodule

// File: tb/bridge_fault_inj_tb_top.sv
`timescale 1ns/1ps
module bridge_fault_inj_tb_top;
  localparam int N  = 6;
  localparam int TW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_wr;
  logic          cfg_en;
  logic [3:0]    cfg_code;
  logic [TW-1:0] cfg_target;
  logic [N-1:0]  src_a, src_b;
  logic [N-1:0]  dst_a, dst_b, short_flag;

  int    n_vec  = 0;
  int    n_miss = 0;
  string cur_req = "R1";

  bit       m_en;
  int       m_code;
  int       m_tgt;

  always #2.5 clk = ~clk;

  bridge_fault_inj #(.NUM_PAIRS(N), .TGT_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
    .cfg_code(cfg_code), .cfg_target(cfg_target),
    .src_a(src_a), .src_b(src_b),
    .dst_a(dst_a), .dst_b(dst_b), .short_flag(short_flag));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en <= 0; m_code <= 0; m_tgt <= 0;
    end else if (cfg_wr) begin
      m_en <= cfg_en; m_code <= int'(cfg_code); m_tgt <= int'(cfg_target);
    end
  end

  task automatic check_now();
    logic [N-1:0] ea, eb, ef;
    for (int i = 0; i < N; i++) begin
      bit a = src_a[i];
      bit b = src_b[i];
      ea[i] = a; eb[i] = b; ef[i] = 1'b0;
      if (m_en && m_tgt == i) begin
        case (m_code)
          1: begin ea[i] = a & b; eb[i] = a & b; end
          2: begin ea[i] = a | b; eb[i] = a | b; end
          3: begin ea[i] = a;     eb[i] = a;     end
          4: begin ea[i] = b;     eb[i] = b;     end
          5: eb[i] = a & b;
          6: ea[i] = a & b;
          7: eb[i] = a | b;
          8: ea[i] = a | b;
          default: ;
        endcase
        if (m_code >= 1 && m_code <= 8 && a != b) ef[i] = 1'b1;
      end
    end
    n_vec++;
    if (dst_a !== ea || dst_b !== eb || short_flag !== ef) begin
      n_miss++;
      $display("FAIL %s: dst_a=%b dst_b=%b flag=%b expected dst_a=%b dst_b=%b flag=%b (en=%0d code=%0d tgt=%0d)",
               cur_req, dst_a, dst_b, short_flag, ea, eb, ef, m_en, m_code, m_tgt);
    end
  endtask

  task automatic step(input bit wr, input bit en, input int code, input int tgt);
    @(negedge clk);
    cfg_wr = wr; cfg_en = en; cfg_code = 4'(code); cfg_target = TW'(tgt);
    src_a = N'($urandom); src_b = N'($urandom);
    #1 check_now();
  endtask

  initial begin
    #200000;
    n_miss++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

  initial begin
    rst_n = 0; cfg_wr = 0; cfg_en = 0; cfg_code = 0; cfg_target = 0;
    src_a = '0; src_b = '0;
    repeat (3) @(posedge clk);
    cur_req = "R1";
    for (int k = 0; k < 4; k++) step(0, 1, 1, 0);
    @(negedge clk) rst_n = 1;
    for (int k = 0; k < 6; k++) step(0, 1, 5, 2);

    cur_req = "R3";
    for (int c = 0; c < 16; c++)
      for (int t = 0; t < 8; t++) begin
        step(1, 0, c, t);
        step(0, 0, c, t);
      end

    for (int c = 0; c < 16; c++) begin
      if (c == 0 || c > 8) cur_req = "R8";
      else if (c <= 2) cur_req = "R4";
      else if (c <= 4) cur_req = "R5";
      else if (c <= 6) cur_req = "R6";
      else cur_req = "R7";
      for (int t = 0; t < 8; t++) begin
        if (t >= N) cur_req = "R9";
        step(1, 1, c, t);
        for (int k = 0; k < 8; k++) step(0, 1, c, t);
      end
    end

    cur_req = "R10";
    for (int k = 0; k < 40; k++) step(1, 1, 1 + (k % 8), k % N);

    cur_req = "R2";
    step(1, 1, 3, 1);
    for (int k = 0; k < 30; k++) step(0, k[0], k % 16, k % 8);
    for (int k = 0; k < 30; k++) step(1, 1, k % 16, k % 8);

    cur_req = "R1";
    @(negedge clk) rst_n = 0;
    #1 check_now();
    @(negedge clk) rst_n = 1;
    for (int k = 0; k < 4; k++) step(0, 1, 2, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end
endmodule